// File: doc/BRIEF.md
# Serial Programming Port with Latch Routing

This block is the programming front end of a frequency synthesizer. A host drives three slow wires: a serial clock, a data line and a load strobe. Each rising edge of the serial clock pushes one data bit into a 24-bit shift register, with the most significant bit sent first. A rising edge on the load strobe commits the whole word to one of four holding latches. The latches are the reference divider word, the N divider word, the function word and the initialization word.

The two lowest bits of the shifted word choose the destination. The full 24-bit word, including those two bits, is stored in the selected latch. A write to the initialization latch stores the same word in the function latch as well. All three wires are asynchronous to the system clock. The block brings them into the system clock domain with a synchronizer chain and works only on edges seen after that chain.

A small state machine runs the commit. In ST_IDLE the block shifts and waits. A synchronized strobe rise is the transition T_STROBE: it snapshots the shift register and moves to ST_COMMIT. ST_COMMIT writes the decoded latch for exactly one cycle. From ST_COMMIT, T_DONE_LOW returns to ST_IDLE if the strobe is already low, and T_DONE_HIGH enters ST_HOLD if the strobe is still high. In ST_HOLD, T_RELEASE returns to ST_IDLE once the strobe falls.

Top module: `synth_prog_port`

## Requirements
- R1: While reset is low, all four latch outputs read zero, and they still read zero on the first cycle after reset is released.
- R2: On each synchronized rising edge of the serial clock, the shift register moves left by one bit and takes the data line into bit 0. The first bit sent therefore ends up in bit 23 after 24 edges.
- R3: Shifting never changes any latch. Latches change only as a result of a load strobe rising edge.
- R4: When the committed word has bits [1:0] = 00, the word is written to the reference divider latch (`ref_word`).
- R5: When the committed word has bits [1:0] = 01, the word is written to the N divider latch (`ndiv_word`).
- R6: When the committed word has bits [1:0] = 10, the word is written to the function latch (`func_word`), and no other latch changes.
- R7: When the committed word has bits [1:0] = 11, the same word is written to both the initialization latch (`init_word`) and the function latch.
- R8: If more than 24 bits are shifted before a strobe, only the last 24 bits sent are committed.
- R9: A latch output changes on the fourth rising system clock edge that samples the strobe high, counting the first such edge as one. That is two synchronizer stages, one edge-detect register and one commit cycle. The word committed is the shift register contents at the moment of the synchronized rise.
- R10: While the strobe stays high after a commit, further shifting does not commit again. A new commit needs the strobe to fall and rise again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock from host (asynchronous) |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe; rising edge commits the word |
| ref_word | output | 24 | Reference divider latch contents |
| ndiv_word | output | 24 | N divider latch contents |
| func_word | output | 24 | Function latch contents |
| init_word | output | 24 | Initialization latch contents |

## Verification
The hardest case to reach from the ports is a strobe that is still high while a second word shifts in. This is the ST_HOLD path, and a design that commits on the strobe level would pass every ordinary single-word test. The stimulus raises the strobe, holds it high while shifting a complete new word, checks that the N divider latch keeps the earlier value, and then drops and raises the strobe to show that the new word lands. Overlong words and the exact commit cycle are driven as well. A behavioural model built from queues of sampled pin values checks all four latches on every clock.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

    // Destination code carried in bits [1:0] of the shifted word
    typedef enum logic [1:0] {
        DEST_REF  = 2'b00,
        DEST_NDIV = 2'b01,
        DEST_FUNC = 2'b10,
        DEST_INIT = 2'b11
    } dest_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COMMIT = 2'd1,
        ST_HOLD   = 2'd2
    } commit_state_e;

    localparam int NUM_LATCH = 4;
    localparam int CODE_W    = 2;

endpackage

// File: rtl/sp_sync_edge.sv
module sp_sync_edge #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] level,
    output logic [W-1:0] rise
);

    logic [STAGES-1:0][W-1:0] chain;
    logic [W-1:0]             prev;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '0;
        else        prev <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~prev;

endmodule

// File: rtl/sp_shift_reg.sv
module sp_shift_reg #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] word
);

    logic [W-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sr <= '0;
        else if (shift_en) sr <= {sr[W-2:0], bit_in};
    end

    assign word = sr;

endmodule

// File: rtl/sp_commit_fsm.sv
module sp_commit_fsm
    import synth_prog_pkg::*;
#(
    parameter int W = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 le_rise,
    input  logic                 le_level,
    input  logic [W-1:0]         word_in,
    output logic [NUM_LATCH-1:0] wr,
    output logic [W-1:0]         word_out
);

    commit_state_e state, state_nx;
    logic [W-1:0]  word_q;
    dest_e         dest;

    // State register and snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            word_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && le_rise) word_q <= word_in;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (le_rise)  state_nx = ST_COMMIT;   // T_STROBE
            ST_COMMIT: state_nx = le_level ? ST_HOLD         // T_DONE_HIGH
                                           : ST_IDLE;        // T_DONE_LOW
            ST_HOLD:   if (!le_level) state_nx = ST_IDLE;    // T_RELEASE
            default:   state_nx = ST_IDLE;
        endcase
    end

    assign dest = dest_e'(word_q[CODE_W-1:0]);

    // Outputs
    always_comb begin
        wr = '0;
        unique case (state)
            ST_COMMIT: begin
                unique case (dest)
                    DEST_REF:  wr[DEST_REF]  = 1'b1;
                    DEST_NDIV: wr[DEST_NDIV] = 1'b1;
                    DEST_FUNC: wr[DEST_FUNC] = 1'b1;
                    DEST_INIT: begin
                        wr[DEST_INIT] = 1'b1;
                        wr[DEST_FUNC] = 1'b1;
                    end
                    default: wr = '0;
                endcase
            end
            ST_IDLE, ST_HOLD: wr = '0;
            default:          wr = '0;
        endcase
    end

    assign word_out = word_q;

endmodule

// File: rtl/sp_latch_bank.sv
module sp_latch_bank #(
    parameter int W = 24,
    parameter int N = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        wr,
    input  logic [W-1:0]        word,
    output logic [N-1:0][W-1:0] q
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_latch
            logic [W-1:0] r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     r <= '0;
                else if (wr[i]) r <= word;
            end
            assign q[i] = r;
        end
    endgenerate

endmodule

// File: rtl/synth_prog_port.sv
module synth_prog_port
    import synth_prog_pkg::*;
#(
    parameter int WORD_W      = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_le,
    output logic [WORD_W-1:0] ref_word,
    output logic [WORD_W-1:0] ndiv_word,
    output logic [WORD_W-1:0] func_word,
    output logic [WORD_W-1:0] init_word
);

    localparam int LINE_CLK  = 2;
    localparam int LINE_DATA = 1;
    localparam int LINE_LE   = 0;

    logic [2:0]                      lines_lvl, lines_rise;
    logic                            shift_pulse, data_lvl, le_rise, le_lvl;
    logic [WORD_W-1:0]               shift_word, commit_word;
    logic [NUM_LATCH-1:0]            wr_vec;
    logic [NUM_LATCH-1:0][WORD_W-1:0] bank_q;

    sp_sync_edge #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_clk, ser_data, ser_le}),
        .level (lines_lvl),
        .rise  (lines_rise)
    );

    assign shift_pulse = lines_rise[LINE_CLK];
    assign data_lvl    = lines_lvl[LINE_DATA];
    assign le_rise     = lines_rise[LINE_LE];
    assign le_lvl      = lines_lvl[LINE_LE];

    sp_shift_reg #(.W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_pulse),
        .bit_in   (data_lvl),
        .word     (shift_word)
    );

    sp_commit_fsm #(.W(WORD_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .le_rise  (le_rise),
        .le_level (le_lvl),
        .word_in  (shift_word),
        .wr       (wr_vec),
        .word_out (commit_word)
    );

    sp_latch_bank #(.W(WORD_W), .N(NUM_LATCH)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_vec),
        .word  (commit_word),
        .q     (bank_q)
    );

    assign ref_word  = bank_q[DEST_REF];
    assign ndiv_word = bank_q[DEST_NDIV];
    assign func_word = bank_q[DEST_FUNC];
    assign init_word = bank_q[DEST_INIT];

endmodule

// File: rtl/synth_prog_port_chk.sv
module synth_prog_port_chk #(
    parameter int W = 24
) (
    input logic         clk,
    input logic         rst_n,
    input logic         shift_en,
    input logic         bit_in,
    input logic [W-1:0] sreg,
    input logic         le_rise,
    input logic [3:0]   wr,
    input logic [W-1:0] ref_word,
    input logic [W-1:0] ndiv_word,
    input logic [W-1:0] func_word,
    input logic [W-1:0] init_word
);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ref_word == '0 && ndiv_word == '0 && func_word == '0 && init_word == '0)); // R1
    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (sreg[0] == $past(bit_in) && sreg[W-1:1] == $past(sreg[W-2:0]))); // R2
    AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(sreg)); // R2
    AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr[0] |=> $stable(ref_word)); // R3
    AST_NDIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr[1] |=> $stable(ndiv_word)); // R3
    AST_FUNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr[2] |=> $stable(func_word)); // R3
    AST_INIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr[3] |=> $stable(init_word)); // R3
    AST_REF_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        wr[0] |=> ref_word[1:0] == 2'b00); // R4
    AST_NDIV_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        wr[1] |=> ndiv_word[1:0] == 2'b01); // R5
    AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr[0], wr[1], wr[2]})); // R6
    AST_INIT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        wr[3] |-> wr[2]); // R7
    AST_INIT_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        wr[3] |=> (init_word == func_word && init_word[1:0] == 2'b11)); // R7
    AST_WRITE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr != 4'b0) |-> $past(le_rise)); // R9

endmodule

bind synth_prog_port synth_prog_port_chk #(.W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_pulse),
    .bit_in    (data_lvl),
    .sreg      (shift_word),
    .le_rise   (le_rise),
    .wr        (wr_vec),
    .ref_word  (ref_word),
    .ndiv_word (ndiv_word),
    .func_word (func_word),
    .init_word (init_word)
);

// File: tb/synth_prog_port_test.sv
module synth_prog_port_test;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
    logic [23:0] ref_word, ndiv_word, func_word, init_word;

    synth_prog_port uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_data  (ser_data),
        .ser_le    (ser_le),
        .ref_word  (ref_word),
        .ndiv_word (ndiv_word),
        .func_word (func_word),
        .init_word (init_word)
    );

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    // Behavioural reference: queue of sampled pins, delayed edges
    logic [23:0] m_sr, m_snap;
    logic [23:0] m_lat [4];
    bit          m_pend;
    logic [2:0]  hist [$];
    logic [2:0]  h2, h3;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sr = '0; m_snap = '0; m_pend = 1'b0;
            for (int i = 0; i < 4; i++) m_lat[i] = '0;
            hist = '{3'b0, 3'b0, 3'b0};
        end else begin
            h2 = hist[1];
            h3 = hist[2];
            if (m_pend) begin
                m_lat[m_snap[1:0]] = m_snap;
                if (m_snap[1:0] == 2'b11) m_lat[2] = m_snap;
                m_pend = 1'b0;
            end
            if (h2[0] && !h3[0]) begin
                m_snap = m_sr;
                m_pend = 1'b1;
            end
            if (h2[2] && !h3[2]) m_sr = {m_sr[22:0], h2[1]};
            hist.push_front({ser_clk, ser_data, ser_le});
            void'(hist.pop_back());
        end
    end

    // Per-cycle comparison against the model (R9 covers timing of every write)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (ref_word != m_lat[0] || ndiv_word != m_lat[1] ||
                func_word != m_lat[2] || init_word != m_lat[3]) begin
                fails++;
                $display("FAIL R9 per-cycle: actual %h %h %h %h expected %h %h %h %h",
                         ref_word, ndiv_word, func_word, init_word,
                         m_lat[0], m_lat[1], m_lat[2], m_lat[3]);
            end
        end
    end

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [63:0] v, input int n);
        for (int b = n - 1; b >= 0; b--) begin
            ser_data = v[b];
            repeat (3) @(negedge clk);
            ser_clk = 1'b1;
            repeat (3) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic strobe();
        ser_le = 1'b1;
        repeat (4) @(negedge clk);
        ser_le = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 ref reset", ref_word, 24'h0);
        chk("R1 ndiv reset", ndiv_word, 24'h0);
        chk("R1 func reset", func_word, 24'h0);
        chk("R1 init reset", init_word, 24'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", ref_word | ndiv_word | func_word | init_word, 24'h0);

        // R2 R4: MSB-first word routed to reference latch
        send_bits(64'hA5C3F0, 24);
        strobe();
        chk("R2 R4 ref word", ref_word, 24'hA5C3F0);
        chk("R4 ndiv untouched", ndiv_word, 24'h0);

        // R3: shifting alone changes nothing
        send_bits(64'h2AB, 10);
        chk("R3 ref after shift", ref_word, 24'hA5C3F0);
        chk("R3 ndiv after shift", ndiv_word, 24'h0);

        // R5
        send_bits(64'h3E9151, 24);
        strobe();
        chk("R5 ndiv word", ndiv_word, 24'h3E9151);

        // R6
        send_bits(64'h812346, 24);
        strobe();
        chk("R6 func word", func_word, 24'h812346);
        chk("R6 init untouched", init_word, 24'h0);
        chk("R6 ref untouched", ref_word, 24'hA5C3F0);

        // R7
        send_bits(64'h0F0F0F, 24);
        strobe();
        chk("R7 init word", init_word, 24'h0F0F0F);
        chk("R7 func mirror", func_word, 24'h0F0F0F);

        // R8: 32 bits sent, last 24 kept (code 00)
        send_bits(64'hFF123454, 32);
        strobe();
        chk("R8 overlong", ref_word, 24'h123454);

        // R10: strobe held high across a second word
        send_bits(64'h44440D, 24);
        ser_le = 1'b1;
        repeat (8) @(negedge clk);
        chk("R10 first commit", ndiv_word, 24'h44440D);
        send_bits(64'h999995, 24);
        chk("R10 no recommit", ndiv_word, 24'h44440D);
        ser_le = 1'b0;
        repeat (6) @(negedge clk);
        strobe();
        chk("R10 after re-strobe", ndiv_word, 24'h999995);

        // R9: exact commit cycle
        send_bits(64'h13579A, 24);
        ser_le = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 before commit", func_word, 24'h0F0F0F);
        @(negedge clk);
        chk("R9 at commit", func_word, 24'h13579A);
        ser_le = 1'b0;
        repeat (8) @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

endmodule